// File: doc/BRIEF.md
# Pattern Loop Iteration Controller

This block sits beside a microcoded memory-timing sequencer and decides how often a marked section of the running pattern repeats. When a pattern starts, it picks one of three 4-bit repeat counts: one for reads, one for writes, one for periodic refresh service. As pattern words execute, it records the address of the first word that carries the loop-start marker. Each time a word carrying the loop-end marker executes, it spends one iteration. While iterations remain, it tells the sequencer to jump back to the recorded address. Otherwise the sequencer falls through to the next word.

The block also drives one shared pad that works in one of two modes. In the first, the pad is an extra general-purpose output that follows a bit of the pattern word. In the second, the pad is an input that holds the sequencer on its current word for as long as it is high.

Top module: `loop_iter_ctrl`

## Requirements
- R1: After reset, `branch_back` is low and `ret_addr` is zero. The iteration counter is empty, so a loop-end word executed before any start does not branch.
- R2: On a cycle with `start` high, the counter loads the field chosen by `cyc_type`: 2'b00 selects `cfg_rd_loops`, 2'b01 selects `cfg_wr_loops`, and 2'b10 or 2'b11 selects `cfg_rf_loops`. The same read or write field applies whether the access is a burst or a single beat.
- R3: A field value of 1 to 15 gives that many passes through the loop body. A field value of 0 gives 16 passes. One pass is one executed loop-end word.
- R4: A word executes when `step_ok` is high and `start` is low. On an executed loop-end word, `branch_back` is high in the same cycle if more than one iteration remains, and the counter decrements. When only one iteration remains, the sequencer falls through and the counter reaches zero. Further loop-end words do not branch.
- R5: `ret_addr` is the `cur_addr` of the first executed loop-start word after the last start. The output shows this value in the same cycle that word executes. Later loop-start words do not change it. A start resets it to zero.
- R6: Marker inputs seen in a `start` cycle are ignored. In that cycle `branch_back` is low, and no address is recorded.
- R7: While `cfg_wait_mode` is 0, `pin_oe` is 1, `pin_out` equals `word_gpl4`, and `pin_in` has no effect: `step_ok` equals `word_valid`.
- R8: While `cfg_wait_mode` is 1, `pin_oe` and `pin_out` are 0. While `pin_in` is high, `step_ok` and `branch_back` are low, and the counter and the recorded address stay unchanged.
- R9: `branch_back` is high only when `step_ok` and `loop_end` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rd_loops | input | 4 | Repeat count for read cycles (0 means 16) |
| cfg_wr_loops | input | 4 | Repeat count for write cycles (0 means 16) |
| cfg_rf_loops | input | 4 | Repeat count for refresh service (0 means 16) |
| cfg_wait_mode | input | 1 | 1: shared pad is a wait input; 0: it is a general output |
| start | input | 1 | Pattern start strobe |
| cyc_type | input | 2 | Cycle type of the starting pattern |
| word_valid | input | 1 | A pattern word is presented this cycle |
| cur_addr | input | AW | Address of the presented word |
| loop_start | input | 1 | Presented word carries the loop-start marker |
| loop_end | input | 1 | Presented word carries the loop-end marker |
| word_gpl4 | input | 1 | General-output bit of the presented word |
| pin_in | input | 1 | Level sensed on the shared pad |
| step_ok | output | 1 | Presented word may execute this cycle |
| branch_back | output | 1 | Jump to `ret_addr` instead of the next word |
| ret_addr | output | AW | Recorded loop-start address |
| pin_out | output | 1 | Drive value for the shared pad |
| pin_oe | output | 1 | Output enable for the shared pad |

## Verification
The bench runs each cycle type with a zero field and counts branches. A design that treated zero as zero iterations, or that picked the wrong field for the 2'b11 code, would show the wrong branch total. It also puts loop-end words into start cycles and into cycles stalled by the wait input. A design that let those words through would lose an iteration or branch while the sequencer is frozen. Loop-start words that come again after the address has been recorded catch a design that keeps overwriting the return address. Random passes with `cfg_wait_mode` off check that the pad level never leaks into stepping.

// File: rtl/loop_iter_pkg.sv
package loop_iter_pkg;
  localparam int FIELD_W = 4;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    CYC_READ    = 2'b00,
    CYC_WRITE   = 2'b01,
    CYC_REFRESH = 2'b10,
    CYC_SPARE   = 2'b11
  } cyc_e;

  // a zero field stands for the largest count, 2**FIELD_W
  function automatic logic [CNT_W-1:0] expand_count(input logic [FIELD_W-1:0] f);
    if (f == '0) return CNT_W'(1) << FIELD_W;
    return {1'b0, f};
  endfunction

  function automatic logic [CNT_W-1:0] spend(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction
endpackage

// File: rtl/loop_field_sel.sv
module loop_field_sel
  import loop_iter_pkg::*;
(
  input  logic [FIELD_W-1:0] rd_field,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic [FIELD_W-1:0] rf_field,
  input  logic [1:0]         cyc,
  output logic [CNT_W-1:0]   load_val
);
  logic [FIELD_W-1:0] picked;

  always_comb begin
    unique case (cyc_e'(cyc))
      CYC_READ:  picked = rd_field;
      CYC_WRITE: picked = wr_field;
      default:   picked = rf_field;
    endcase
    load_val = expand_count(picked);
  end
endmodule

// File: rtl/loop_counter.sv
module loop_counter
  import loop_iter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             more
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= spend(cnt);
  end

  assign more = (cnt > CNT_W'(1));
endmodule

// File: rtl/loop_anchor.sv
module loop_anchor #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          mark_exec,
  input  logic [AW-1:0] addr,
  output logic          anchored,
  output logic          take_now,
  output logic [AW-1:0] ret_q,
  output logic [AW-1:0] ret_addr
);
  assign take_now = mark_exec && !anchored;
  assign ret_addr = take_now ? addr : ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anchored <= 1'b0;
      ret_q    <= '0;
    end else if (clear) begin
      anchored <= 1'b0;
      ret_q    <= '0;
    end else if (take_now) begin
      anchored <= 1'b1;
      ret_q    <= addr;
    end
  end
endmodule

// File: rtl/pin_share.sv
module pin_share (
  input  logic wait_mode,
  input  logic pin_in,
  input  logic word_gpl4,
  input  logic word_valid,
  output logic stall,
  output logic step_ok,
  output logic pin_out,
  output logic pin_oe
);
  assign stall   = wait_mode && pin_in;
  assign step_ok = word_valid && !stall;
  assign pin_oe  = !wait_mode;
  assign pin_out = wait_mode ? 1'b0 : word_gpl4;
endmodule

// File: rtl/loop_iter_ctrl.sv
module loop_iter_ctrl
  import loop_iter_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] cfg_rd_loops,
  input  logic [FIELD_W-1:0] cfg_wr_loops,
  input  logic [FIELD_W-1:0] cfg_rf_loops,
  input  logic               cfg_wait_mode,
  input  logic               start,
  input  logic [1:0]         cyc_type,
  input  logic               word_valid,
  input  logic [AW-1:0]      cur_addr,
  input  logic               loop_start,
  input  logic               loop_end,
  input  logic               word_gpl4,
  input  logic               pin_in,
  output logic               step_ok,
  output logic               branch_back,
  output logic [AW-1:0]      ret_addr,
  output logic               pin_out,
  output logic               pin_oe
);
  // named internal events, used by the bound checker
  logic             stall;
  logic             exec;
  logic             end_exec;
  logic             more;
  logic             anchored;
  logic             take_now;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    ret_q;

  pin_share u_pin (
    .wait_mode (cfg_wait_mode),
    .pin_in    (pin_in),
    .word_gpl4 (word_gpl4),
    .word_valid(word_valid),
    .stall     (stall),
    .step_ok   (step_ok),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  assign exec     = step_ok && !start;
  assign end_exec = exec && loop_end;

  loop_field_sel u_sel (
    .rd_field(cfg_rd_loops),
    .wr_field(cfg_wr_loops),
    .rf_field(cfg_rf_loops),
    .cyc     (cyc_type),
    .load_val(load_val)
  );

  loop_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .load_val(load_val),
    .dec     (end_exec),
    .cnt     (cnt),
    .more    (more)
  );

  loop_anchor #(.AW(AW)) u_anchor (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .mark_exec(exec && loop_start),
    .addr     (cur_addr),
    .anchored (anchored),
    .take_now (take_now),
    .ret_q    (ret_q),
    .ret_addr (ret_addr)
  );

  assign branch_back = end_exec && more;
endmodule

// File: rtl/loop_iter_ctrl_chk.sv
module loop_iter_ctrl_chk
  import loop_iter_pkg::*;
#(
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             cfg_wait_mode,
  input logic             pin_in,
  input logic             loop_end,
  input logic             step_ok,
  input logic             branch_back,
  input logic             pin_oe,
  input logic             end_exec,
  input logic             anchored,
  input logic [CNT_W-1:0] cnt,
  input logic [AW-1:0]    ret_q
);
  p_branch_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_back |-> (step_ok && loop_end));

  p_wait_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wait_mode && pin_in) |-> (!step_ok && !branch_back));

  p_pad_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wait_mode |-> !pin_oe);

  p_load_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt != '0 && cnt <= (CNT_W'(1) << FIELD_W)));

  p_spend_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (end_exec && !start && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_anchor_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (anchored && !start) |=> (anchored && $stable(ret_q)));

  p_start_no_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !branch_back);
endmodule

bind loop_iter_ctrl loop_iter_ctrl_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .cfg_wait_mode(cfg_wait_mode),
  .pin_in       (pin_in),
  .loop_end     (loop_end),
  .step_ok      (step_ok),
  .branch_back  (branch_back),
  .pin_oe       (pin_oe),
  .end_exec     (end_exec),
  .anchored     (anchored),
  .cnt          (cnt),
  .ret_q        (ret_q)
);

// File: tb/loop_iter_ctrl_tb.sv
`timescale 1ns/1ps
module loop_iter_ctrl_tb;
  localparam int AW = 6;
  localparam time TCK = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] rd_f = '0, wr_f = '0, rf_f = '0;
  logic wm = 1'b0, st = 1'b0, wv = 1'b0, ls = 1'b0, le = 1'b0, g4 = 1'b0, pin = 1'b0;
  logic [1:0] ct = '0;
  logic [AW-1:0] addr = '0;
  logic step_ok, branch_back, pin_out, pin_oe;
  logic [AW-1:0] ret_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  int m_cnt = 0;
  bit m_anch = 0;
  int m_ret = 0;
  int br_seen = 0;

  always #(TCK/2) clk = ~clk;

  loop_iter_ctrl #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_rd_loops(rd_f), .cfg_wr_loops(wr_f), .cfg_rf_loops(rf_f),
    .cfg_wait_mode(wm), .start(st), .cyc_type(ct), .word_valid(wv),
    .cur_addr(addr), .loop_start(ls), .loop_end(le), .word_gpl4(g4),
    .pin_in(pin), .step_ok(step_ok), .branch_back(branch_back),
    .ret_addr(ret_addr), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int iters(input logic [3:0] f);
    return (f == 4'd0) ? 16 : int'(f);
  endfunction

  function automatic int pick(input logic [1:0] t);
    if (t == 2'b00) return iters(rd_f);
    if (t == 2'b01) return iters(wr_f);
    return iters(rf_f);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // one cycle: drive at the falling edge, check, then advance the model at the rising edge
  task automatic cyc(input bit s, input logic [1:0] t, input bit v, input bit m_ls,
                     input bit m_le, input bit b4, input bit p, input int a);
    bit e_stall, e_step, e_exec, e_br, e_take;
    int e_ret;
    st = s; ct = t; wv = v; ls = m_ls; le = m_le; g4 = b4; pin = p; addr = AW'(a);
    #1;
    e_stall = wm && p;
    e_step  = v && !e_stall;
    e_exec  = e_step && !s;
    e_br    = e_exec && m_le && (m_cnt > 1);
    e_take  = e_exec && m_ls && !m_anch;
    e_ret   = e_take ? a : m_ret;
    chk(wm ? "R8 step_ok" : "R7 step_ok", int'(step_ok), int'(e_step));
    chk(s ? "R6 branch_back" : "R4/R9 branch_back", int'(branch_back), int'(e_br));
    chk("R5 ret_addr", int'(ret_addr), e_ret);
    chk(wm ? "R8 pin_oe" : "R7 pin_oe", int'(pin_oe), int'(!wm));
    chk(wm ? "R8 pin_out" : "R7 pin_out", int'(pin_out), wm ? 0 : int'(b4));
    if (branch_back) br_seen++;
    @(posedge clk);
    if (s) begin
      m_cnt = pick(t); m_anch = 0; m_ret = 0;
    end else if (e_exec) begin
      if (m_le && m_cnt > 0) m_cnt--;
      if (e_take) begin m_anch = 1; m_ret = a; end
    end
    @(negedge clk);
  endtask

  // runs body 10(start mark),11,12(end mark) until fall-through; returns branches seen
  task automatic run_loop(input logic [1:0] t, input bit stall_mid, output int nbr);
    int pc;
    cyc(1, t, 1, 1, 1, 0, 0, 9);   // marks during start must be ignored (R6)
    br_seen = 0; pc = 10;
    for (int g = 0; g < 80 && pc != 13; g++) begin
      if (stall_mid && g == 5) cyc(0, t, 1, 0, 1, 0, 1, 12); // frozen loop-end word (R8)
      cyc(0, t, 1, pc == 10, pc == 12, pc[0], 0, pc);
      if (pc == 12) pc = branch_q ? 10 : 13;
      else pc++;
    end
    nbr = br_seen;
  endtask

  bit branch_q;
  always @(posedge clk) branch_q <= branch_back;

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int nbr;
    void'($urandom(32'h5eed_1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 branch_back", int'(branch_back), 0);
    chk("R1 ret_addr", int'(ret_addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    cyc(0, 0, 1, 0, 1, 0, 0, 3);   // R1: empty counter, loop-end does not branch
    chk("R1 no branch before start", br_seen, 0);

    // R2/R3: each cycle type, including zero meaning sixteen
    rd_f = 4'd3; wr_f = 4'd0; rf_f = 4'd7;
    for (int t = 0; t < 4; t++) begin
      run_loop(2'(t), 0, nbr);
      chk("R2/R3 branch count", nbr, pick(2'(t)) - 1);
    end
    rd_f = 4'd0; wr_f = 4'd1; rf_f = 4'd15;
    for (int t = 0; t < 3; t++) begin
      run_loop(2'(t), 0, nbr);
      chk("R3 branch count", nbr, pick(2'(t)) - 1);
    end
    // R4: exhausted counter does not branch
    cyc(0, 0, 1, 0, 1, 0, 0, 12);
    // R8: stall in wait mode leaves count unchanged
    wm = 1'b1; rd_f = 4'd4;
    run_loop(2'b00, 1, nbr);
    chk("R8 branch count with stall", nbr, 3);
    // R7: pad level ignored in output mode
    wm = 1'b0;
    run_loop(2'b01, 1, nbr);
    chk("R7 pin_in ignored", nbr, 0);

    // random mix
    for (int k = 0; k < 300; k++) begin
      wm = 1'($urandom);
      rd_f = 4'($urandom); wr_f = 4'($urandom); rf_f = 4'($urandom);
      cyc(1, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), int'(AW'($urandom)));
      for (int j = 0; j < 30; j++) begin
        cyc(0, 2'($urandom), ($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 3) == 0,
            1'($urandom), ($urandom % 4) == 0, int'(AW'($urandom)));
      end
    end
    finish_run();
  end
endmodule